// File: doc/BRIEF.md
# Daisy-Chainable SPI Diagnostic Slave

This block is an 8-bit SPI target for a motor-bridge controller. Each frame carries a command from the host and returns, in the same frame, the answer to the command of the previous frame. The supported commands are: read the diagnosis word, clear the diagnosis, read the revision, read control, write control (answer with control), and write control (answer with diagnosis). Control data is held in a 5-bit register whose bits drive the bridge logic. A clear command sends a one-cycle pulse to the fault supervisor.

Between the start of a frame and the first rising SCK edge, SO shows a shutdown flag OR'd with SI. With SO wired to SI of the next device, a host can read a chain-wide fault indication without clocking. SPI pins are treated as synchronous to `clk_i` and are sampled by it, so an input synchronizer is assumed upstream. Edges of CSN and SCK are found by comparing each sample with the previous one.

Top module: `diag_spi_slave`

## Requirements
- R1: While `csn_i` is high, `so_oe_o` is 0. While `csn_i` is low, `so_oe_o` is 1.
- R2: From a falling CSN until the first rising SCK edge of the frame, `so_o` equals `fault_off_i | si_i`, combinationally.
- R3: From the first rising SCK edge on, `so_o` shows the reply word MSB first. Each later rising edge advances one bit. SI is captured on falling SCK edges, MSB first.
- R4: The reply in a frame answers the command of the previous decoded frame. After reset, the first reply is the revision word `{4'b0010, rev_i}`.
- R5: The command is bits 7:5 of the received word. Reply selection is: 000, 100 and 110 give `diag_i`. 001 gives the revision word. 011 and 111 give `{3'b000, ctrl_o}`. Any other code gives `diag_i`. The reply value is taken when the next frame starts.
- R6: Commands 111 and 110 load bits 4:0 into `ctrl_o`. The bit layout is [4] open-load source off, [3] SPI steering, [2] SPI enable, [1] SPI direction, [0] SPI PWM. `ctrl_o` resets to 0.
- R7: When a control write occurs while any of `dis_i`, `pwm_i`, `dir_i` is high, the written value of bit 3 is ignored and its old value is kept. The other bits are still written.
- R8: Command 100 produces a `diag_clr_o` pulse exactly one clock long, on CSN rising.
- R9: A frame with no falling SCK edge changes neither `ctrl_o` nor the next reply. A frame with fewer than 8 clocks is still decoded. The receive shifter is cleared at frame start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| csn_i | input | 1 | Chip select, active low |
| sck_i | input | 1 | Serial clock |
| si_i | input | 1 | Serial data in |
| so_o | output | 1 | Serial data out |
| so_oe_o | output | 1 | Output enable for SO pad |
| diag_i | input | 8 | Diagnosis word from the fault supervisor |
| rev_i | input | 4 | Revision field |
| fault_off_i | input | 1 | Outputs shut down by fault or disable |
| dis_i | input | 1 | Bridge disable pin level |
| pwm_i | input | 1 | PWM pin level |
| dir_i | input | 1 | Direction pin level |
| ctrl_o | output | 5 | Control register |
| diag_clr_o | output | 1 | One-cycle diagnosis clear pulse |

## Verification
The hardest situation to reach is the one-frame lag between command and answer across unusual frames. A frame with no clocks must leave the pending reply untouched. A short frame must still decode from a shifter that was cleared at frame start. The bench sets up a known pending reply and then sends a clockless frame followed by a full frame. It also sends a 4-clock frame whose leading zero bits come from the cleared shifter. The SIN lock is reached by first writing the bit to 0, then raising one pin level during a write of all ones.

// File: rtl/diag_spi_pkg.sv
package diag_spi_pkg;
  localparam int unsigned WORD_W = 8;
  localparam int unsigned CMD_W  = 3;
  localparam int unsigned CTRL_W = WORD_W - CMD_W;
  localparam int unsigned REV_W  = 4;
  localparam int unsigned SIN_BIT = 3;
  localparam int unsigned CNT_W  = $clog2(WORD_W + 1);

  typedef enum logic [CMD_W-1:0] {
    CMD_RD_DIAG  = 3'b000,
    CMD_RD_REV   = 3'b001,
    CMD_RD_CTRL  = 3'b011,
    CMD_CLR_DIAG = 3'b100,
    CMD_WR_DIAG  = 3'b110,
    CMD_WR_CTRL  = 3'b111
  } cmd_e;

  typedef enum logic [1:0] {
    SEL_DIAG = 2'd0,
    SEL_REV  = 2'd1,
    SEL_CTRL = 2'd2
  } reply_sel_e;
endpackage

// File: rtl/diag_spi_edge.sv
module diag_spi_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic csn_i,
  input  logic sck_i,
  output logic csn_fall_o,
  output logic csn_rise_o,
  output logic sck_rise_o,
  output logic sck_fall_o
);
  logic csn_q, sck_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      csn_q <= 1'b1;
      sck_q <= 1'b0;
    end else begin
      csn_q <= csn_i;
      sck_q <= sck_i;
    end
  end

  assign csn_fall_o = csn_q & ~csn_i;
  assign csn_rise_o = ~csn_q & csn_i;
  assign sck_rise_o = ~sck_q & sck_i & ~csn_i;
  assign sck_fall_o = sck_q & ~sck_i & ~csn_i;
endmodule

// File: rtl/diag_spi_shift.sv
module diag_spi_shift
  import diag_spi_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              csn_i,
  input  logic              si_i,
  input  logic              fault_off_i,
  input  logic              csn_fall_i,
  input  logic              sck_rise_i,
  input  logic              sck_fall_i,
  input  logic [WORD_W-1:0] reply_i,
  output logic [WORD_W-1:0] rx_word_o,
  output logic              got_fall_o,
  output logic              so_o,
  output logic              so_oe_o
);
  logic [WORD_W-1:0] tx_q, rx_q;
  logic              seen_rise_q, got_fall_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q        <= '0;
      rx_q        <= '0;
      seen_rise_q <= 1'b0;
      got_fall_q  <= 1'b0;
    end else if (csn_fall_i) begin
      tx_q        <= reply_i;
      rx_q        <= '0;
      seen_rise_q <= 1'b0;
      got_fall_q  <= 1'b0;
    end else begin
      if (sck_rise_i) begin
        // first rise exposes the MSB, later ones advance
        if (seen_rise_q) tx_q <= {tx_q[WORD_W-2:0], 1'b0};
        seen_rise_q <= 1'b1;
      end
      if (sck_fall_i) begin
        rx_q       <= {rx_q[WORD_W-2:0], si_i};
        got_fall_q <= 1'b1;
      end
    end
  end

  assign so_oe_o    = ~csn_i;
  assign so_o       = seen_rise_q ? tx_q[WORD_W-1] : (fault_off_i | si_i);
  assign rx_word_o  = rx_q;
  assign got_fall_o = got_fall_q;
endmodule

// File: rtl/diag_spi_cmd.sv
module diag_spi_cmd
  import diag_spi_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_end_i,
  input  logic [WORD_W-1:0] rx_word_i,
  input  logic [WORD_W-1:0] diag_i,
  input  logic [REV_W-1:0]  rev_i,
  input  logic              pins_idle_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              diag_clr_o,
  output logic [WORD_W-1:0] reply_o
);
  localparam logic [WORD_W-REV_W-1:0] REV_HEAD = (WORD_W-REV_W)'(4'b0010);

  reply_sel_e        sel_q, sel_d;
  logic [CTRL_W-1:0] ctrl_q, ctrl_wr;
  logic              clr_q, do_write;
  logic [CMD_W-1:0]  cmd;

  assign cmd = rx_word_i[WORD_W-1 -: CMD_W];

  always_comb begin
    unique case (cmd)
      CMD_RD_REV:              sel_d = SEL_REV;
      CMD_RD_CTRL, CMD_WR_CTRL: sel_d = SEL_CTRL;
      default:                 sel_d = SEL_DIAG;
    endcase
  end

  assign do_write = (cmd == CMD_WR_CTRL) || (cmd == CMD_WR_DIAG);

  always_comb begin
    ctrl_wr = rx_word_i[CTRL_W-1:0];
    if (!pins_idle_i) ctrl_wr[SIN_BIT] = ctrl_q[SIN_BIT];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q  <= SEL_REV;
      ctrl_q <= '0;
      clr_q  <= 1'b0;
    end else begin
      clr_q <= frame_end_i && (cmd == CMD_CLR_DIAG);
      if (frame_end_i) begin
        sel_q <= sel_d;
        if (do_write) ctrl_q <= ctrl_wr;
      end
    end
  end

  always_comb begin
    unique case (sel_q)
      SEL_REV:  reply_o = {REV_HEAD, rev_i};
      SEL_CTRL: reply_o = {{CMD_W{1'b0}}, ctrl_q};
      default:  reply_o = diag_i;
    endcase
  end

  assign ctrl_o     = ctrl_q;
  assign diag_clr_o = clr_q;
endmodule

// File: rtl/diag_spi_slave.sv
module diag_spi_slave
  import diag_spi_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              csn_i,
  input  logic              sck_i,
  input  logic              si_i,
  output logic              so_o,
  output logic              so_oe_o,
  input  logic [WORD_W-1:0] diag_i,
  input  logic [REV_W-1:0]  rev_i,
  input  logic              fault_off_i,
  input  logic              dis_i,
  input  logic              pwm_i,
  input  logic              dir_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              diag_clr_o
);
  logic csn_fall, csn_rise, sck_rise, sck_fall, got_fall;
  logic [WORD_W-1:0] rx_word, reply;

  diag_spi_edge u_edge (
    .clk_i, .rst_ni, .csn_i, .sck_i,
    .csn_fall_o(csn_fall), .csn_rise_o(csn_rise),
    .sck_rise_o(sck_rise), .sck_fall_o(sck_fall)
  );

  diag_spi_shift u_shift (
    .clk_i, .rst_ni, .csn_i, .si_i, .fault_off_i,
    .csn_fall_i(csn_fall), .sck_rise_i(sck_rise), .sck_fall_i(sck_fall),
    .reply_i(reply), .rx_word_o(rx_word), .got_fall_o(got_fall),
    .so_o, .so_oe_o
  );

  diag_spi_cmd u_cmd (
    .clk_i, .rst_ni,
    .frame_end_i(csn_rise & got_fall),
    .rx_word_i(rx_word), .diag_i, .rev_i,
    .pins_idle_i(~(dis_i | pwm_i | dir_i)),
    .ctrl_o, .diag_clr_o, .reply_o(reply)
  );
endmodule

// File: rtl/diag_spi_slave_chk.sv
module diag_spi_slave_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       csn_i,
  input logic       so_oe_o,
  input logic       dis_i,
  input logic       pwm_i,
  input logic       dir_i,
  input logic [4:0] ctrl_o,
  input logic       diag_clr_o
);
  // R1
  oe_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csn_i |-> !so_oe_o);
  // R1
  oe_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !csn_i |-> so_oe_o);
  // R8
  clr_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    diag_clr_o |=> !diag_clr_o);
  // R8
  clr_at_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(diag_clr_o) |-> $past(csn_i));
  // R6
  ctrl_at_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ctrl_o) |-> $past(csn_i));
  // R7
  sin_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ctrl_o[3]) |-> $past(!dis_i && !pwm_i && !dir_i));
endmodule

bind diag_spi_slave diag_spi_slave_chk u_chk (
  .clk_i, .rst_ni, .csn_i, .so_oe_o, .dis_i, .pwm_i, .dir_i, .ctrl_o, .diag_clr_o
);

// File: tb/diag_spi_slave_tb.sv
module diag_spi_slave_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic csn = 1'b1, sck = 1'b0, si = 1'b0;
  logic so, so_oe;
  logic [7:0] diag = 8'hDF;
  logic [3:0] rev = 4'h5;
  logic fault_off = 1'b0, dis = 1'b0, pwm = 1'b0, dir = 1'b0;
  logic [4:0] ctrl;
  logic diag_clr;
  int n_chk = 0, n_fail = 0, clr_cnt = 0;

  always #2.5 clk = ~clk;

  diag_spi_slave dut_i (
    .clk_i(clk), .rst_ni(rst_n), .csn_i(csn), .sck_i(sck), .si_i(si),
    .so_o(so), .so_oe_o(so_oe), .diag_i(diag), .rev_i(rev),
    .fault_off_i(fault_off), .dis_i(dis), .pwm_i(pwm), .dir_i(dir),
    .ctrl_o(ctrl), .diag_clr_o(diag_clr)
  );

  always @(posedge clk) if (diag_clr) clr_cnt <= clr_cnt + 1;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  task automatic xfer(input logic [7:0] cmd, input int nclk, output logic [7:0] rsp);
    rsp = '0;
    csn = 1'b0; steps(2);
    for (int i = 7; i > 7 - nclk; i--) begin
      si = cmd[i]; sck = 1'b1; steps(2);
      rsp[i] = so;
      sck = 1'b0; steps(2);
    end
    csn = 1'b1; si = 1'b0; steps(3);
  endtask

  task automatic t_reset();
    check("R1 reset oe", {7'd0, so_oe}, 8'd0);
    check("R6 reset ctrl", {3'd0, ctrl}, 8'd0);
    check("R8 reset clr", {7'd0, diag_clr}, 8'd0);
  endtask

  task automatic t_first_rev();
    logic [7:0] r;
    xfer(8'h00, 8, r);
    check("R4 first reply revision", r, {4'b0010, rev});
    xfer(8'h20, 8, r);            // read revision next
    check("R5 rd diag reply", r, diag);
    diag = 8'hC3;
    xfer(8'h00, 8, r);
    check("R4 rev reply", r, {4'b0010, rev});
    xfer(8'h40, 8, r);            // unknown code 010
    check("R3 rd diag live value", r, 8'hC3);
    xfer(8'h00, 8, r);
    check("R5 unknown cmd gives diag", r, 8'hC3);
  endtask

  task automatic t_ctrl();
    logic [7:0] r;
    xfer(8'hF6, 8, r);            // 111_10110
    check("R6 write ctrl", {3'd0, ctrl}, 8'h16);
    xfer(8'h60, 8, r);            // read control
    check("R5 wr ctrl returns ctrl", r, 8'h16);
    xfer(8'hC9, 8, r);            // 110_01001
    check("R5 rd ctrl reply", r, 8'h16);
    check("R6 combined write", {3'd0, ctrl}, 8'h09);
    xfer(8'h00, 8, r);
    check("R5 combined write returns diag", r, diag);
  endtask

  task automatic t_sin_lock();
    logic [7:0] r;
    xfer(8'hE0, 8, r);
    dir = 1'b1;
    xfer(8'hFF, 8, r);
    dir = 1'b0;
    check("R7 SIN held while pin high", {3'd0, ctrl}, 8'h17);
    dis = 1'b1;
    xfer(8'hE8, 8, r);
    dis = 1'b0;
    check("R7 SIN held while dis high", {3'd0, ctrl}, 8'h00);
    xfer(8'hE8, 8, r);
    check("R7 SIN accepted when idle", {3'd0, ctrl}, 8'h08);
  endtask

  task automatic t_clear();
    logic [7:0] r;
    clr_cnt = 0;
    xfer(8'h80, 8, r);
    check("R8 one clear pulse", clr_cnt[7:0], 8'd1);
    xfer(8'h20, 8, r);
    check("R5 clear returns diag", r, diag);
    check("R8 no pulse on other cmd", clr_cnt[7:0], 8'd1);
  endtask

  task automatic t_frames();
    logic [7:0] r;
    xfer(8'hF5, 8, r);            // pending reply: revision (from 001 before)
    xfer(8'h60, 8, r);            // pending: ctrl = 0x15
    csn = 1'b0; steps(4); csn = 1'b1; steps(3);
    check("R9 clockless keeps ctrl", {3'd0, ctrl}, 8'h15);
    xfer(8'h00, 8, r);
    check("R9 clockless keeps reply", r, 8'h15);
    xfer(8'hFF, 4, r);            // rx = 0000_1111 -> cmd 000
    xfer(8'h00, 8, r);
    check("R9 short frame decoded", r, diag);
    check("R9 short frame no write", {3'd0, ctrl}, 8'h15);
  endtask

  task automatic t_flag();
    csn = 1'b0; fault_off = 1'b1; si = 1'b0; steps(2);
    check("R1 oe in frame", {7'd0, so_oe}, 8'd1);
    check("R2 flag shown", {7'd0, so}, 8'd1);
    fault_off = 1'b0; si = 1'b1; #1;
    check("R2 SI passes through", {7'd0, so}, 8'd1);
    si = 1'b0; #1;
    check("R2 both low", {7'd0, so}, 8'd0);
    csn = 1'b1; steps(3);
    check("R1 oe off after frame", {7'd0, so_oe}, 8'd0);
  endtask

  initial begin
    fork
      begin
        steps(3); rst_n = 1'b1; steps(2);
        t_reset();
        t_first_rev();
        t_ctrl();
        t_sin_lock();
        t_clear();
        t_frames();
        t_flag();
      end
      begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule